// File: doc/BRIEF.md
# PDM-to-PCM CIC Decimator with Output Gain

This block converts a one-bit pulse-density stream from a digital microphone into signed multi-bit samples at a lower rate. A cascade of integrators runs at the input rate, a matching cascade of differentiators (combs) runs once per decimation period, and the result is scaled by an 8-bit multiplier and an arithmetic right shift. The scaling normalises the large gain that the cascade itself adds.

All settings arrive on one 32-bit control word that a register file would normally drive. The settings are the stage count, the decimation ratio, the gain multiplier, the gain shift and an enable bit. Typical settings are seven stages, a ratio of eight, a multiplier of 0x80 and a shift of 21. The block serves a single channel. A new input bit is offered with a one-cycle strobe, and each finished sample leaves with a one-cycle strobe.

Top module: `cic_decimator_gain`

## Requirements
- R1: The control word holds the stage count in bits [3:0], the ratio in bits [8:4], the multiplier (unsigned) in bits [23:16], the shift in bits [29:24] and the enable in bit 31. The fields other than the enable change only while the enable is clear.
- R2: An input bit of 1 enters the first integrator as +1 and a bit of 0 enters as -1. With two stages, a ratio of 4, a multiplier of 1 and a shift of 0, a stream of all ones yields 10 and then 16 in steady state.
- R3: For a ratio R, exactly one sample is produced per R accepted input bits, starting at the R-th bit after enable. A ratio field of 0 acts as a ratio of 1.
- R4: out_valid is high for one cycle, two rising edges after the edge that accepts the bit completing a decimation period (the accepting edge counts as the first).
- R5: The filter result never exceeds R to the power N in magnitude for any legal setting. The accumulators are sized for MAX_STAGES stages and a ratio of 31.
- R6: A stage count of 0 acts as 1, and a count above MAX_STAGES (8 by default) acts as MAX_STAGES.
- R7: Each sample equals (filter_result × multiplier) arithmetically shifted right by the shift field, with shifts up to 63.
- R8: A scaled value outside the signed 24-bit range saturates to 8388607 or to -8388608.
- R9: While the enable is clear, no sample is produced and input strobes are ignored. Clearing the enable empties all integrator, comb and phase state, so that the next enabled run matches a freshly reset filter.
- R10: Cycles with in_valid low change no filter state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | 32 | Packed control fields and enable |
| in_valid | input | 1 | Strobe: in_bit holds a new PDM bit |
| in_bit | input | 1 | One-bit PDM input |
| out_valid | output | 1 | One-cycle strobe for a finished sample |
| out_sample | output | 24 | Signed, scaled and saturated sample |

## Verification
The hardest state to reach is a comb output close to the growth limit, where the accumulators must hold R^N without loss while the integrators themselves wrap. The stimulus reaches it with long runs of constant ones and zeros at eight stages and a ratio of 31, which also drives the gain stage into both saturation rails. Randomly gapped input with random configurations then exercises the wrapping integrators against a 64-bit reference model over many decimation periods. A second enable after a disabled window, in which input strobes keep arriving, shows that no old state survives.

// File: rtl/cic_dec_pkg.sv
package cic_dec_pkg;

   localparam int STG_LSB = 0;
   localparam int STG_W   = 4;
   localparam int RAT_LSB = 4;
   localparam int RAT_W   = 5;
   localparam int MUL_LSB = 16;
   localparam int MUL_W   = 8;
   localparam int SHF_LSB = 24;
   localparam int SHF_W   = 6;
   localparam int EN_BIT  = 31;

   typedef struct packed {
      logic             en;
      logic [SHF_W-1:0] shift;
      logic [MUL_W-1:0] mult;
      logic [RAT_W-1:0] ratio;
      logic [STG_W-1:0] stages;
   } cic_cfg_t;

   function automatic cic_cfg_t cfg_unpack(input logic [31:0] w);
      cic_cfg_t c;
      c.en     = w[EN_BIT];
      c.shift  = w[SHF_LSB +: SHF_W];
      c.mult   = w[MUL_LSB +: MUL_W];
      c.ratio  = w[RAT_LSB +: RAT_W];
      c.stages = w[STG_LSB +: STG_W];
      return c;
   endfunction

endpackage

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
   parameter int STAGES = 8,
   parameter int ACC_W  = 41
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    step,
   input  logic                    in_bit,
   input  logic [STAGES-1:0]       active,
   output logic signed [ACC_W-1:0] tap
);

   logic signed [ACC_W-1:0] acc_q [STAGES];
   logic signed [ACC_W-1:0] acc_d [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_int
      logic signed [ACC_W-1:0] src;
      if (k == 0) begin : g_first
         assign src = in_bit ? {{(ACC_W-1){1'b0}}, 1'b1} : {ACC_W{1'b1}};
      end else begin : g_next
         assign src = acc_d[k-1];
      end
      assign acc_d[k] = active[k] ? acc_q[k] + src : acc_q[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) acc_q[k] <= '0;
      end else if (clr) begin
         for (int k = 0; k < STAGES; k++) acc_q[k] <= '0;
      end else if (step) begin
         for (int k = 0; k < STAGES; k++) acc_q[k] <= acc_d[k];
      end
   end

   always_comb begin
      tap = acc_q[0];
      for (int k = 1; k < STAGES; k++) begin
         if (active[k]) tap = acc_q[k];
      end
   end

   // R9: a clear leaves every integrator at zero
   assert_integ_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (tap == '0));

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
   parameter int STAGES = 8,
   parameter int ACC_W  = 41
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    fire,
   input  logic [STAGES-1:0]       active,
   input  logic signed [ACC_W-1:0] din,
   output logic signed [ACC_W-1:0] dout
);

   logic signed [ACC_W-1:0] dly_q [STAGES];
   logic signed [ACC_W-1:0] s_in  [STAGES];
   logic signed [ACC_W-1:0] s_out [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_comb
      if (k == 0) begin : g_first
         assign s_in[k] = din;
      end else begin : g_next
         assign s_in[k] = s_out[k-1];
      end
      assign s_out[k] = active[k] ? s_in[k] - dly_q[k] : s_in[k];
   end

   assign dout = s_out[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) dly_q[k] <= '0;
      end else if (clr) begin
         for (int k = 0; k < STAGES; k++) dly_q[k] <= '0;
      end else if (fire) begin
         for (int k = 0; k < STAGES; k++) begin
            if (active[k]) dly_q[k] <= s_in[k];
         end
      end
   end

endmodule

// File: rtl/cic_gain_stage.sv
module cic_gain_stage #(
   parameter int ACC_W  = 41,
   parameter int MUL_W  = 8,
   parameter int SHF_W  = 6,
   parameter int OUT_W  = 24
) (
   input  logic signed [ACC_W-1:0] din,
   input  logic [MUL_W-1:0]        mult,
   input  logic [SHF_W-1:0]        shift,
   output logic signed [OUT_W-1:0] dout
);

   localparam int PROD_W = ACC_W + MUL_W + 1;
   localparam logic signed [PROD_W-1:0] HI_LIM =
      {{(PROD_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [PROD_W-1:0] LO_LIM =
      {{(PROD_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   if (OUT_W > PROD_W) begin : g_bad_width
      $error("cic_gain_stage: OUT_W wider than product");
   end

   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] shifted;

   always_comb begin
      prod    = PROD_W'(din) * PROD_W'($signed({1'b0, mult}));
      shifted = prod >>> shift;
      if (shifted > HI_LIM)      dout = HI_LIM[OUT_W-1:0];
      else if (shifted < LO_LIM) dout = LO_LIM[OUT_W-1:0];
      else                       dout = shifted[OUT_W-1:0];
   end

endmodule

// File: rtl/cic_decimator_gain.sv
module cic_decimator_gain
   import cic_dec_pkg::*;
#(
   parameter int MAX_STAGES = 8,
   parameter int OUT_W      = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [31:0]             ctl_word,
   input  logic                    in_valid,
   input  logic                    in_bit,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_sample
);

   localparam int ACC_W = MAX_STAGES * RAT_W + 1;

   if (MAX_STAGES < 2 || MAX_STAGES > 15) begin : g_bad_stages
      $error("cic_decimator_gain: MAX_STAGES must be 2..15");
   end
   if (OUT_W < 2) begin : g_bad_out
      $error("cic_decimator_gain: OUT_W too small");
   end

   cic_cfg_t cfg;
   assign cfg = cfg_unpack(ctl_word);

   logic [STG_W-1:0]      n_eff;
   logic [RAT_W-1:0]      ratio_eff;
   logic [MAX_STAGES-1:0] active;

   always_comb begin
      if (cfg.stages == '0)                n_eff = STG_W'(1);
      else if (int'(cfg.stages) > MAX_STAGES) n_eff = STG_W'(MAX_STAGES);
      else                                 n_eff = cfg.stages;
      ratio_eff = (cfg.ratio == '0) ? RAT_W'(1) : cfg.ratio;
   end

   for (genvar k = 0; k < MAX_STAGES; k++) begin : g_mask
      assign active[k] = (int'(n_eff) > k);
   end

   logic [RAT_W-1:0] phase_q;
   logic             dec_q;
   logic             accept;
   logic             at_last;

   assign accept  = cfg.en & in_valid;
   assign at_last = (phase_q == ratio_eff - RAT_W'(1));

   logic signed [ACC_W-1:0] integ_tap;
   logic signed [ACC_W-1:0] comb_out;
   logic signed [OUT_W-1:0] gain_out;

   cic_integ_chain #(.STAGES(MAX_STAGES), .ACC_W(ACC_W)) i_integ (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!cfg.en),
      .step   (accept),
      .in_bit (in_bit),
      .active (active),
      .tap    (integ_tap)
   );

   cic_comb_chain #(.STAGES(MAX_STAGES), .ACC_W(ACC_W)) i_comb (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!cfg.en),
      .fire   (dec_q),
      .active (active),
      .din    (integ_tap),
      .dout   (comb_out)
   );

   cic_gain_stage #(.ACC_W(ACC_W), .MUL_W(MUL_W), .SHF_W(SHF_W), .OUT_W(OUT_W)) i_gain (
      .din   (comb_out),
      .mult  (cfg.mult),
      .shift (cfg.shift),
      .dout  (gain_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= '0;
         dec_q      <= 1'b0;
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else if (!cfg.en) begin
         phase_q    <= '0;
         dec_q      <= 1'b0;
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         dec_q     <= accept & at_last;
         out_valid <= dec_q;
         if (accept) phase_q <= at_last ? '0 : phase_q + RAT_W'(1);
         if (dec_q)  out_sample <= gain_out;
      end
   end

   // growth bound R^N for the assertion below
   logic [ACC_W-1:0]      bound;
   logic signed [ACC_W:0] comb_ext;
   logic signed [ACC_W:0] comb_mag;

   always_comb begin
      bound = ACC_W'(1);
      for (int k = 0; k < MAX_STAGES; k++) begin
         if (active[k]) bound = bound * ACC_W'(ratio_eff);
      end
      comb_ext = (ACC_W+1)'(comb_out);
      comb_mag = (comb_ext < 0) ? -comb_ext : comb_ext;
   end

   // R5: the decimated result stays within the growth bound
   assert_cic_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dec_q |-> (comb_mag <= $signed({1'b0, bound})));

   // R4: a sample leaves only one edge after a decimation event
   assert_out_follows_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(dec_q));

   // R9: disabled means quiet and cleared
   assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.en |=> (!out_valid && !dec_q && phase_q == '0));

   // R10: idle cycles keep the phase
   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.en && !in_valid) |=> $stable(phase_q));

endmodule

// File: tb/test_cic_decimator_gain.sv
module test_cic_decimator_gain;

   localparam int CLK_PERIOD = 10;
   localparam int MAXS       = 8;
   localparam longint SAT_HI = 8388607;
   localparam longint SAT_LO = -8388608;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [31:0]        ctl = '0;
   logic               in_valid = 1'b0;
   logic               in_bit = 1'b0;
   logic               out_valid;
   logic signed [23:0] out_sample;

   cic_decimator_gain i_cic_decimator_gain (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_word   (ctl),
      .in_valid   (in_valid),
      .in_bit     (in_bit),
      .out_valid  (out_valid),
      .out_sample (out_sample)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int     total = 0;
   int     bad = 0;
   longint cyc = 0;
   int     seen = 0;
   longint last_out = 0;
   longint exp_v[$];
   longint exp_c[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // reference model state
   longint integ[MAXS];
   longint dly[MAXS];
   int m_n, m_r, m_mult, m_shift, m_cnt;

   function automatic longint sat_gain(input longint v, input int mult, input int shift);
      longint p;
      p = v * longint'(mult);
      p = p >>> shift;
      if (p > SAT_HI) return SAT_HI;
      if (p < SAT_LO) return SAT_LO;
      return p;
   endfunction

   task automatic model_load(input int stg, input int rat, input int mult, input int shift);
      m_n = (stg == 0) ? 1 : ((stg > MAXS) ? MAXS : stg);
      m_r = (rat == 0) ? 1 : rat;
      m_mult = mult;
      m_shift = shift;
      m_cnt = 0;
      for (int k = 0; k < MAXS; k++) begin
         integ[k] = 0;
         dly[k] = 0;
      end
   endtask

   task automatic model_push(input bit b);
      longint v, t;
      for (int k = 0; k < m_n; k++)
         integ[k] += (k == 0) ? (b ? 64'sd1 : -64'sd1) : integ[k-1];
      m_cnt++;
      if (m_cnt == m_r) begin
         m_cnt = 0;
         v = integ[m_n-1];
         for (int k = 0; k < m_n; k++) begin
            t = v - dly[k];
            dly[k] = v;
            v = t;
         end
         exp_v.push_back(sat_gain(v, m_mult, m_shift));
         exp_c.push_back(cyc + 2);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         longint v, c;
         seen++;
         last_out = longint'(out_sample);
         if (exp_v.size() == 0) begin
            check(1'b0, "R9 unexpected sample", 1, 0);
         end else begin
            v = exp_v.pop_front();
            c = exp_c.pop_front();
            check(longint'(out_sample) == v, "R7 sample value", longint'(out_sample), v);
            check(cyc == c, "R4 output cycle", cyc, c);
         end
      end
   end

   task automatic drive(input bit v, input bit b);
      @(negedge clk);
      in_valid = v;
      in_bit = b;
      if (v && ctl[31]) model_push(b);
   endtask

   task automatic run(input int stg, input int rat, input int mult, input int shift,
                      input int nsamp, input int mode);
      @(negedge clk);
      ctl[31] = 1'b0;
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      model_load(stg, rat, mult, shift);
      ctl = {1'b1, 1'b0, 6'(shift), 8'(mult), 7'b0, 5'(rat), 4'(stg)};
      for (int i = 0; i < nsamp; i++) begin
         if (mode == 1)      drive(1'b1, 1'b1);
         else if (mode == 2) drive(1'b1, 1'b0);
         else                drive(($urandom % 10) < 7, 1'($urandom % 2));
      end
      repeat (5) drive(1'b0, 1'b0);
      check(exp_v.size() == 0, "R3 all expected samples arrived", exp_v.size(), 0);
   endtask

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);
      check(out_sample == '0, "R9 reset out_sample", out_sample, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2: mapping and steady state 4^2
      run(2, 4, 1, 0, 12, 1);
      check(last_out == 16, "R2 steady state two stages ratio 4", last_out, 16);

      // R6: stage field 0 acts as one stage
      run(0, 4, 1, 0, 12, 1);
      check(last_out == 4, "R6 stage field zero", last_out, 4);
      // R6: stage field 12 clamps to 8 stages
      run(12, 2, 1, 0, 40, 1);
      check(last_out == 256, "R6 stage field clamp", last_out, 256);

      // R3: ratio field 0 acts as 1, one sample per bit
      begin
         int s0;
         s0 = seen;
         run(1, 0, 1, 0, 20, 1);
         check(seen - s0 == 20, "R3 ratio zero sample count", seen - s0, 20);
         check(last_out == 1, "R3 ratio zero value", last_out, 1);
      end

      // R8 and R5: maximum growth, both rails
      run(8, 31, 255, 0, 93, 1);
      check(last_out == SAT_HI, "R8 positive saturation", last_out, SAT_HI);
      run(8, 31, 255, 0, 93, 2);
      check(last_out == SAT_LO, "R8 negative saturation", last_out, SAT_LO);
      // R5: maximum growth scaled back into range, exact value checked by model
      run(8, 31, 1, 20, 93, 1);

      // R7: full shift of negative and positive results
      run(3, 4, 200, 63, 24, 2);
      check(last_out == -1, "R7 shift 63 negative", last_out, -1);
      run(3, 4, 200, 63, 24, 1);
      check(last_out == 0, "R7 shift 63 positive", last_out, 0);

      // R1, R10: typical setting with gapped random input
      run(7, 8, 8'h80, 6'h15, 1600, 0);
      run(5, 13, 37, 9, 1300, 0);

      // R9: strobes while disabled are ignored, then a fresh run
      begin
         int s0;
         @(negedge clk);
         ctl[31] = 1'b0;
         s0 = seen;
         for (int i = 0; i < 60; i++) drive(1'b1, 1'($urandom % 2));
         repeat (4) drive(1'b0, 1'b0);
         check(seen == s0, "R9 no samples while disabled", seen - s0, 0);
         check(out_valid == 1'b0, "R9 out_valid low while disabled", out_valid, 0);
      end
      run(5, 13, 37, 9, 400, 0);

      // random configurations
      for (int it = 0; it < 6; it++) begin
         run(1 + int'($urandom % 8), 1 + int'($urandom % 31), int'($urandom % 256),
             int'($urandom % 40), 400, 0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog expired", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule